// File: doc/BRIEF.md
# Pipelined Constant Divide-by-Five Unit

This block takes an unsigned dividend with a valid strobe and returns the floor of that value divided by five, with a matching valid strobe a fixed number of cycles later. It uses no multiplier and no iterative divider. It multiplies the dividend by a fixed-point reciprocal of one fifth. The reciprocal is built as a chain of registered shift-and-add stages. The factors are 3, 17, 257 and 65537, and each one has exactly two set bits. Each stage doubles the length of the repeating 0011 pattern, and with it the number of correct reciprocal bits.

The full variant has four stages, which form the 32-bit constant 0x33333333. The final stage adds the dividend once more, so the effective multiplier is 0x33333334. The 32-bit right shift that follows then gives the exact floor for every input of the default width. A parameter selects a reduced variant with three stages. That variant forms the 16-bit constant 0x3333, adds the same correction and shifts right by 16. It accepts one operand per clock in both variants and suits datapaths where a quotient by five is needed at full throughput.

Top module: `div5_pipe`

## Requirements
- R1: With the default parameters (21-bit dividend, four stages), `quo` equals floor(`dvd` / 5) for every dividend value.
- R2: With four stages, `quo_vld` is high exactly 4 rising edges after the edge that sampled `dvd_vld` high, carrying the result for that dividend.
- R3: A new dividend may be presented on every clock. Results emerge one per clock, in the order the dividends were accepted.
- R4: A cycle with `dvd_vld` low produces no result: `quo_vld` is low in the matching output cycle.
- R5: While `rst` is high at a rising edge, every in-flight valid bit is cleared. `quo_vld` is low from the cycle after the first reset edge until a new dividend has travelled the full pipeline after release.
- R6: With `NSTAGE` = 3 (reduced variant), the latency is 3 rising edges, and `quo` equals floor(`dvd` / 5) for every dividend below 16384.
- R7: In the reduced variant, `quo` is never less than floor(`dvd` / 5), for any dividend.
- R8: `quo` is `IN_W`-2 bits wide (19 by default). The largest dividends, 2097150 and 2097151, both give 419430.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; clears the valid pipeline |
| dvd_vld | input | 1 | High when `dvd` carries a dividend to divide |
| dvd | input | IN_W (21) | Unsigned dividend |
| quo_vld | output | 1 | High when `quo` carries a result |
| quo | output | IN_W-2 (19) | Floor of the dividend divided by five |

## Verification
A short table of hand-computed operands is streamed with a bubble between entries. It covers values just below, at and just above multiples of five, the top of the input range and the 2^14 edge of the reduced variant. This separates an uncorrected reciprocal, which rounds exact multiples one too low, from a correct one. It also shows that bubbles produce no result. Every dividend below 16384 is then streamed back-to-back into both variants. This checks the reduced variant's exact region and ordering at full rate. A strided sweep across the rest of the range, plus a dense run at the top, checks exactness of the full variant and the over-estimate bound of the reduced variant. Finally, single-shot and mid-stream-reset tests measure the latency of each variant and confirm that reset discards in-flight results.

// File: rtl/div5_pkg.sv
package div5_pkg;

   // Reciprocal width produced by a chain of nst factor stages (3 -> 16, 4 -> 32).
   function automatic int recip_w(input int nst);
      return 2 << nst;
   endfunction

   // Left shift used by factor stage idx: factors 3, 17, 257, 65537.
   function automatic int stage_shift(input int idx);
      return (idx == 0) ? 1 : (2 << idx);
   endfunction

endpackage

// File: rtl/div5_stage.sv
module div5_stage #(
   parameter int PW      = 54,
   parameter int IN_W    = 21,
   parameter int SH      = 1,
   parameter bit ADD_DIV = 1'b0
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            in_vld,
   input  logic [PW-1:0]   in_sum,
   input  logic [IN_W-1:0] in_div,
   output logic            out_vld,
   output logic [PW-1:0]   out_sum,
   output logic [IN_W-1:0] out_div
);

   localparam int PAD = PW - IN_W;

   logic [PW-1:0] corr;
   logic [PW-1:0] nxt;

   generate
      if (ADD_DIV) begin : g_corr
         assign corr = {{PAD{1'b0}}, in_div};
      end else begin : g_nocorr
         assign corr = '0;
      end
   endgenerate

   always_comb begin
      nxt = in_sum + (in_sum << SH) + corr;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_vld <= 1'b0;
      end else begin
         out_vld <= in_vld;
      end
      out_sum <= nxt;
      out_div <= in_div;
   end

endmodule

// File: rtl/div5_quot.sv
module div5_quot #(
   parameter int PW    = 54,
   parameter int RW    = 32,
   parameter int OUT_W = 19
) (
   input  logic [PW-1:0]    sum,
   output logic [OUT_W-1:0] q
);

   assign q = sum[RW +: OUT_W];

   // Fraction bits and guard bits carry no quotient information.
   logic unused_bits;
   assign unused_bits = ^{sum[RW-1:0], sum[PW-1:RW+OUT_W]};

endmodule

// File: rtl/div5_pipe.sv
module div5_pipe
   import div5_pkg::*;
#(
   parameter int IN_W   = 21,
   parameter int NSTAGE = 4,
   localparam int RW    = recip_w(NSTAGE),
   localparam int PW    = IN_W + RW + 1,
   localparam int OUT_W = IN_W - 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             dvd_vld,
   input  logic [IN_W-1:0]  dvd,
   output logic             quo_vld,
   output logic [OUT_W-1:0] quo
);

   generate
      if (NSTAGE < 3 || NSTAGE > 4) begin : g_bad_nstage
         $error("div5_pipe: NSTAGE must be 3 or 4");
      end
      if (IN_W < 3) begin : g_bad_width
         $error("div5_pipe: IN_W must be at least 3");
      end
   endgenerate

   logic            vld_a [NSTAGE+1];
   logic [PW-1:0]   sum_a [NSTAGE+1];
   logic [IN_W-1:0] div_a [NSTAGE+1];

   assign vld_a[0] = dvd_vld;
   assign sum_a[0] = {{(PW-IN_W){1'b0}}, dvd};
   assign div_a[0] = dvd;

   generate
      for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
         div5_stage #(
            .PW     (PW),
            .IN_W   (IN_W),
            .SH     (stage_shift(g)),
            .ADD_DIV(g == NSTAGE - 1)
         ) u_stage (
            .clk    (clk),
            .rst    (rst),
            .in_vld (vld_a[g]),
            .in_sum (sum_a[g]),
            .in_div (div_a[g]),
            .out_vld(vld_a[g+1]),
            .out_sum(sum_a[g+1]),
            .out_div(div_a[g+1])
         );
      end
   endgenerate

   div5_quot #(
      .PW   (PW),
      .RW   (RW),
      .OUT_W(OUT_W)
   ) u_quot (
      .sum(sum_a[NSTAGE]),
      .q  (quo)
   );

   assign quo_vld = vld_a[NSTAGE];

   logic unused_div;
   assign unused_div = ^div_a[NSTAGE];

endmodule

// File: rtl/div5_chk.sv
module div5_chk #(
   parameter int IN_W   = 21,
   parameter int NSTAGE = 4,
   parameter int OUT_W  = 19
) (
   input logic             clk,
   input logic             rst,
   input logic             dvd_vld,
   input logic [IN_W-1:0]  dvd,
   input logic             quo_vld,
   input logic [OUT_W-1:0] quo
);

   localparam int RW        = 2 << NSTAGE;
   localparam bit ALL_EXACT = (RW - 2 >= IN_W);

   logic            sv [NSTAGE];
   logic [IN_W-1:0] sd [NSTAGE];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < NSTAGE; k++) sv[k] <= 1'b0;
      end else begin
         sv[0] <= dvd_vld;
         for (int k = 1; k < NSTAGE; k++) sv[k] <= sv[k-1];
      end
      sd[0] <= dvd;
      for (int k = 1; k < NSTAGE; k++) sd[k] <= sd[k-1];
   end

   logic [IN_W-1:0] tail;
   logic [IN_W-1:0] true_q;
   logic [63:0]     tail64;
   logic            exact_zone;

   assign tail       = sd[NSTAGE-1];
   assign true_q     = tail / IN_W'(5);
   assign tail64     = 64'(tail);
   assign exact_zone = ALL_EXACT || (tail64 < (64'd1 << (RW - 2)));

   // R2 R3 R4 R6
   lat_chk: assert property (@(posedge clk) disable iff (rst)
      quo_vld == sv[NSTAGE-1]);

   // R1 R6
   quot_exact_chk: assert property (@(posedge clk) disable iff (rst)
      (quo_vld && exact_zone) |-> (IN_W'(quo) == true_q));

   // R7
   no_under_chk: assert property (@(posedge clk) disable iff (rst)
      quo_vld |-> (IN_W'(quo) >= true_q));

   // R5
   reset_clr_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> !quo_vld);

   // R8
   range_chk: assert property (@(posedge clk) disable iff (rst)
      (quo_vld && ALL_EXACT) |-> (IN_W'(quo) <= ({IN_W{1'b1}} / IN_W'(5))));

endmodule

bind div5_pipe div5_chk #(
   .IN_W  (IN_W),
   .NSTAGE(NSTAGE),
   .OUT_W (OUT_W)
) u_chk (.*);

// File: tb/tb_div5_pipe.sv
`timescale 1ns/1ps
module tb_div5_pipe;

   localparam int IN_W  = 21;
   localparam int OUT_W = 19;
   localparam int NTV   = 18;

   // {dividend, expected quotient} worked out by hand
   localparam logic [39:0] TV [NTV] = '{
      {21'd0,       19'd0},
      {21'd1,       19'd0},
      {21'd4,       19'd0},
      {21'd5,       19'd1},
      {21'd9,       19'd1},
      {21'd10,      19'd2},
      {21'd14,      19'd2},
      {21'd15,      19'd3},
      {21'd1000,    19'd200},
      {21'd1004,    19'd200},
      {21'd12345,   19'd2469},
      {21'd16383,   19'd3276},
      {21'd16384,   19'd3276},
      {21'd99999,   19'd19999},
      {21'd1048576, 19'd209715},
      {21'd2097149, 19'd419429},
      {21'd2097150, 19'd419430},
      {21'd2097151, 19'd419430}
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic dvd_vld = 1'b0;
   logic [IN_W-1:0] dvd = '0;
   logic quo_vld, quo_vld_r;
   logic [OUT_W-1:0] quo, quo_r;

   always #2.5 clk = ~clk;

   div5_pipe #(.IN_W(IN_W), .NSTAGE(4)) dut (
      .clk(clk), .rst(rst), .dvd_vld(dvd_vld), .dvd(dvd),
      .quo_vld(quo_vld), .quo(quo));

   div5_pipe #(.IN_W(IN_W), .NSTAGE(3)) dut_r (
      .clk(clk), .rst(rst), .dvd_vld(dvd_vld), .dvd(dvd),
      .quo_vld(quo_vld_r), .quo(quo_r));

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   bit mon_on = 1'b0;
   string phase = "init";

   int qx_f[$], qe_f[$], qx_r[$];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s [%s] actual=%0d expected=%0d", req, phase, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (mon_on && !rst) begin
         if (quo_vld) begin
            if (qe_f.size() == 0) chk(1'b0, "R4", 1, 0);
            else begin
               int x, e;
               x = qx_f.pop_front();
               e = qe_f.pop_front();
               chk(int'(quo) == e, (x >= 2097150) ? "R8" : "R1", int'(quo), e);
            end
         end
         if (quo_vld_r) begin
            if (qx_r.size() == 0) chk(1'b0, "R4", 1, 0);
            else begin
               int x;
               x = qx_r.pop_front();
               if (x < 16384) chk(int'(quo_r) == x / 5, "R6", int'(quo_r), x / 5);
               else           chk(int'(quo_r) >= x / 5, "R7", int'(quo_r), x / 5);
            end
         end
      end
   end

   task automatic send(input int x, input int e);
      @(posedge clk); #1;
      dvd_vld = 1'b1;
      dvd = IN_W'(x);
      qx_f.push_back(x);
      qe_f.push_back(e);
      qx_r.push_back(x);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         dvd_vld = 1'b0;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired in phase %s", phase);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      chk(quo_vld == 1'b0, "R5", int'(quo_vld), 0);
      chk(quo_vld_r == 1'b0, "R5", int'(quo_vld_r), 0);
      mon_on = 1'b1;

      // Table walk with a bubble after each entry (R1 R4 R8)
      phase = "table R4 bubbles";
      for (int i = 0; i < NTV; i++) begin
         send(int'(TV[i][39:19]), int'(TV[i][18:0]));
         idle(1);
      end
      idle(8);

      // Single-shot latency (R2 R6)
      phase = "latency";
      mon_on = 1'b0;
      idle(2);
      begin
         int lf, lr;
         lf = 0; lr = 0;
         @(posedge clk); #1;
         dvd_vld = 1'b1; dvd = IN_W'(777);
         @(posedge clk); #1;
         dvd_vld = 1'b0;
         for (int c = 1; c <= 10; c++) begin
            if (c > 1) @(negedge clk);
            else @(negedge clk);
            if (quo_vld && lf == 0) begin
               lf = c;
               chk(int'(quo) == 155, "R2", int'(quo), 155);
            end
            if (quo_vld_r && lr == 0) begin
               lr = c;
               chk(int'(quo_r) == 155, "R6", int'(quo_r), 155);
            end
         end
         chk(lf == 4, "R2", lf, 4);
         chk(lr == 3, "R6", lr, 3);
      end
      mon_on = 1'b1;

      // Back-to-back stream of every low dividend (R3 R6)
      phase = "R3 dense low";
      for (int x = 0; x < 16384; x++) send(x, x / 5);
      // Strided sweep of the remaining range (R1 R3 R7)
      phase = "R3 sweep";
      for (int x = 16384; x < 2097152; x += 29) send(x, x / 5);
      phase = "R8 top";
      for (int x = 2097152 - 64; x < 2097152; x++) send(x, x / 5);
      idle(10);
      chk(qe_f.size() == 0, "R3", qe_f.size(), 0);
      chk(qx_r.size() == 0, "R3", qx_r.size(), 0);

      // Reset in flight drops results (R5)
      phase = "R5 reset";
      send(50, 10);
      send(55, 11);
      send(60, 12);
      @(posedge clk); #1;
      rst = 1'b1;
      dvd_vld = 1'b1;
      dvd = IN_W'(1234);
      qx_f.delete(); qe_f.delete(); qx_r.delete();
      @(posedge clk);
      for (int c = 0; c < 5; c++) begin
         @(negedge clk);
         chk(quo_vld == 1'b0, "R5", int'(quo_vld), 0);
         chk(quo_vld_r == 1'b0, "R5", int'(quo_vld_r), 0);
      end
      @(posedge clk); #1;
      rst = 1'b0;
      dvd_vld = 1'b0;
      for (int c = 0; c < 6; c++) begin
         @(negedge clk);
         chk(quo_vld == 1'b0, "R5", int'(quo_vld), 0);
         chk(quo_vld_r == 1'b0, "R5", int'(quo_vld_r), 0);
      end

      // Pipeline works again after reset (R1 R6)
      phase = "after reset";
      send(2097150, 419430);
      send(24, 4);
      idle(10);
      chk(qe_f.size() == 0, "R1", qe_f.size(), 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule